// File: doc/BRIEF.md
# CSR Address Window Decoder

This block splits one upstream control/status register bus across several downstream register buses. Every downstream bus has its own address width and the same data width as the upstream side. At elaboration the decoder gives each bus a window of the upstream address space whose size is two to the power of that bus's address width and whose base is aligned to that size. An optional alignment step can be applied before any window. It pushes that window's base up to a larger power-of-two boundary.

In each cycle the upstream address picks at most one window. That window's bus receives the local address, the read strobe, the write strobe and the write data. Every other bus sees zeros. Read data returns through a small two-state steering machine. In state `RS_MISS` the upstream read data is zero. In state `RS_HIT` it follows the bus recorded in the window-index register. On every clock the machine goes to `RS_HIT` (transition *hit*) when the current address falls in a window, and to `RS_MISS` (transition *miss*) when it does not. Reset puts it in `RS_MISS`. As a result, read data always belongs to the address presented one cycle earlier, and reads can be issued back to back.

Top module: `csr_window_decoder`

## Requirements
- R1: Window k spans 2^AW_k addresses on a 2^AW_k boundary. With the defaults (three buses of 10 address bits, and a 12-bit alignment step before the third), the bases are 0x0000, 0x0400 and 0x1000.
- R2: The selected bus gets a local address equal to the low AW_k bits of the upstream address. For example, upstream 0x0402 reaches bus 1 at local address 2.
- R3: The read strobe goes only to the bus whose window holds the upstream address, in the same cycle and without a register.
- R4: The write strobe and write data go only to the selected bus, in the same cycle. Every unselected bus sees write strobe 0, write data 0 and address 0.
- R5: An upstream address outside every window (for example 0x0800 or 0x2000) drives no downstream strobe. It yields read data 0 in the following cycle.
- R6: Upstream read data equals the current read data of the bus selected by the address in the previous cycle. Reads to two windows on consecutive cycles return their data in order, one cycle apart.
- R7: During reset and until the first clock edge after reset, the upstream read data is 0 whatever the address and downstream data are.
- R8: At most one window is selected in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_addr | input | ADDR_W | Upstream address |
| up_r_stb | input | 1 | Upstream read strobe |
| up_w_stb | input | 1 | Upstream write strobe |
| up_w_data | input | DATA_W | Upstream write data |
| up_r_data | output | DATA_W | Upstream read data, steered by last cycle's window |
| dn_addr | output | N_WIN*LOC_W | Local address per bus, bus k in slice k |
| dn_r_stb | output | N_WIN | Read strobe per bus |
| dn_w_stb | output | N_WIN | Write strobe per bus |
| dn_w_data | output | N_WIN*DATA_W | Write data per bus, bus k in slice k |
| dn_r_data | input | N_WIN*DATA_W | Read data per bus, bus k in slice k |

## Verification
The bench probes the first and last address of every window, as well as the unmapped gap that the alignment step leaves below 0x1000. A decoder that ignored the alignment step, or that compared too few address bits, would place the third window at 0x0800 or alias addresses into the gap. It issues reads to different windows on consecutive cycles. A decoder that steered read data from the current address, instead of the previous one, would return the second value one cycle early. It also checks the read data during reset and after a miss, where a select register that failed to clear would leak a stale bus's data. Finally it checks that unselected buses carry zero data and zero address during a write, to catch fan-out that was not gated.

// File: rtl/csr_win_pkg.sv
package csr_win_pkg;

    // Read-steering machine states
    typedef enum logic {
        RS_MISS = 1'b0,
        RS_HIT  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/csr_win_match.sv
module csr_win_match #(
    parameter int     ADDR_W = 16,
    parameter int     LOC_W  = 10,
    parameter int     DATA_W = 8,
    parameter int     AW     = 10,
    parameter longint BASE   = 0
) (
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_r_stb,
    input  logic              up_w_stb,
    input  logic [DATA_W-1:0] up_w_data,
    output logic              hit,
    output logic [LOC_W-1:0]  dn_addr,
    output logic              dn_r_stb,
    output logic              dn_w_stb,
    output logic [DATA_W-1:0] dn_w_data
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] MASK_V = ADDR_W'((longint'(1) << AW) - 1);

    always_comb begin
        hit       = ((up_addr >> AW) == (BASE_V >> AW));
        dn_addr   = hit ? LOC_W'(up_addr & MASK_V) : '0;
        dn_r_stb  = hit & up_r_stb;
        dn_w_stb  = hit & up_w_stb;
        dn_w_data = hit ? up_w_data : '0;
    end

endmodule

// File: rtl/csr_rd_steer.sv
module csr_rd_steer
    import csr_win_pkg::*;
#(
    parameter int N_WIN  = 3,
    parameter int DATA_W = 8,
    parameter int IDX_W  = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_WIN-1:0]        hit,
    input  logic [N_WIN*DATA_W-1:0] dn_r_data,
    output logic [DATA_W-1:0]       up_r_data
);
    rd_state_e          state_q, state_d;
    logic [IDX_W-1:0]   idx_q, idx_d;

    // Next-state selection
    always_comb begin
        state_d = RS_MISS;
        idx_d   = '0;
        for (int k = 0; k < N_WIN; k++) begin
            if (hit[k]) begin
                state_d = RS_HIT;
                idx_d   = IDX_W'(k);
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_MISS;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Output steering
    always_comb begin
        up_r_data = '0;
        unique case (state_q)
            RS_MISS: up_r_data = '0;
            RS_HIT:  up_r_data = dn_r_data[int'(idx_q)*DATA_W +: DATA_W];
            default: up_r_data = '0;
        endcase
    end

    AST_HIT_TO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> (state_q == RS_HIT)); // R6
    AST_MISS_TO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> (state_q == RS_MISS)); // R5

endmodule

// File: rtl/csr_window_decoder.sv
module csr_window_decoder #(
    parameter int                 ADDR_W    = 16,
    parameter int                 DATA_W    = 8,
    parameter int                 N_WIN     = 3,
    parameter logic [N_WIN*8-1:0] SUB_AW    = {8'd10, 8'd10, 8'd10},
    parameter logic [N_WIN*8-1:0] ALIGN_PRE = {8'd12, 8'd0, 8'd0},
    parameter int                 LOC_W     = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       up_addr,
    input  logic                    up_r_stb,
    input  logic                    up_w_stb,
    input  logic [DATA_W-1:0]       up_w_data,
    output logic [DATA_W-1:0]       up_r_data,
    output logic [N_WIN*LOC_W-1:0]  dn_addr,
    output logic [N_WIN-1:0]        dn_r_stb,
    output logic [N_WIN-1:0]        dn_w_stb,
    output logic [N_WIN*DATA_W-1:0] dn_w_data,
    input  logic [N_WIN*DATA_W-1:0] dn_r_data
);
    // Base of window k: optional alignment step, then size alignment
    function automatic longint win_base(input int k);
        longint ptr;
        longint b;
        int     a;
        int     w;
        ptr = 0;
        b   = 0;
        for (int j = 0; j < N_WIN; j++) begin
            a = int'(ALIGN_PRE[j*8 +: 8]);
            w = int'(SUB_AW[j*8 +: 8]);
            if (a > 0) ptr = ((ptr + (longint'(1) << a) - 1) >> a) << a;
            ptr = ((ptr + (longint'(1) << w) - 1) >> w) << w;
            if (j == k) b = ptr;
            ptr = ptr + (longint'(1) << w);
        end
        return b;
    endfunction

    logic [N_WIN-1:0] hit;

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        csr_win_match #(
            .ADDR_W (ADDR_W),
            .LOC_W  (LOC_W),
            .DATA_W (DATA_W),
            .AW     (int'(SUB_AW[i*8 +: 8])),
            .BASE   (win_base(i))
        ) u_match (
            .up_addr   (up_addr),
            .up_r_stb  (up_r_stb),
            .up_w_stb  (up_w_stb),
            .up_w_data (up_w_data),
            .hit       (hit[i]),
            .dn_addr   (dn_addr[i*LOC_W +: LOC_W]),
            .dn_r_stb  (dn_r_stb[i]),
            .dn_w_stb  (dn_w_stb[i]),
            .dn_w_data (dn_w_data[i*DATA_W +: DATA_W])
        );
    end

    csr_rd_steer #(
        .N_WIN  (N_WIN),
        .DATA_W (DATA_W)
    ) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .dn_r_data (dn_r_data),
        .up_r_data (up_r_data)
    );

    // Marks that one edge has passed since reset, so $past is meaningful
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R8
    AST_WSTB_NEEDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_w_stb != '0) |-> up_w_stb); // R4
    AST_RSTB_NEEDS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_r_stb != '0) |-> up_r_stb); // R3
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(hit) == '0)) |-> (up_r_data == '0)); // R5

    for (genvar i = 0; i < N_WIN; i++) begin : g_chk
        AST_RD_STEERED: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(hit[i])) |-> (up_r_data == dn_r_data[i*DATA_W +: DATA_W])); // R6
        AST_WDATA_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
            dn_w_stb[i] |-> (dn_w_data[i*DATA_W +: DATA_W] == up_w_data)); // R4
    end

endmodule

// File: tb/csr_window_decoder_bench.sv
module csr_window_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int N_WIN  = 3;
    localparam int LOC_W  = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [ADDR_W-1:0]       up_addr = '0;
    logic                    up_r_stb = 1'b0;
    logic                    up_w_stb = 1'b0;
    logic [DATA_W-1:0]       up_w_data = '0;
    logic [DATA_W-1:0]       up_r_data;
    logic [N_WIN*LOC_W-1:0]  dn_addr;
    logic [N_WIN-1:0]        dn_r_stb;
    logic [N_WIN-1:0]        dn_w_stb;
    logic [N_WIN*DATA_W-1:0] dn_w_data;
    logic [N_WIN*DATA_W-1:0] dn_r_data = {8'h33, 8'h22, 8'h11};

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_window_decoder u_csr_window_decoder (
        .clk(clk), .rst_n(rst_n), .up_addr(up_addr), .up_r_stb(up_r_stb),
        .up_w_stb(up_w_stb), .up_w_data(up_w_data), .up_r_data(up_r_data),
        .dn_addr(dn_addr), .dn_r_stb(dn_r_stb), .dn_w_stb(dn_w_stb),
        .dn_w_data(dn_w_data), .dn_r_data(dn_r_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N_WIN-1:0] one(input int k);
        return (k < 0) ? '0 : N_WIN'(1) << k;
    endfunction

    // Drive address and strobes, then check combinational fan-out
    task automatic probe(input logic [ADDR_W-1:0] a, input int win, input int loc);
        @(negedge clk);
        up_addr = a; up_r_stb = 1'b1; up_w_stb = 1'b0;
        #1;
        chk(dn_r_stb == one(win), "R1/R3 read strobe window", dn_r_stb, one(win));
        if (win >= 0)
            chk(dn_addr[win*LOC_W +: LOC_W] == LOC_W'(loc), "R2 local address",
                dn_addr[win*LOC_W +: LOC_W], loc);
        chk($countones(dn_r_stb) <= 1, "R8 single window", $countones(dn_r_stb), 1);
    endtask

    task automatic t_reset;
        up_addr = 16'h0005;
        repeat (3) @(negedge clk);
        #1;
        chk(up_r_data == 8'h00, "R7 read data in reset", up_r_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(up_r_data == 8'h00, "R7 read data before first edge", up_r_data, 0);
    endtask

    task automatic t_windows;
        probe(16'h0000, 0, 0);
        probe(16'h03FF, 0, 10'h3FF);
        probe(16'h0400, 1, 0);
        probe(16'h0402, 1, 2);
        probe(16'h07FF, 1, 10'h3FF);
        probe(16'h1000, 2, 0);
        probe(16'h13FF, 2, 10'h3FF);
    endtask

    task automatic t_miss;
        probe(16'h0800, -1, 0);
        probe(16'h0FFF, -1, 0);
        @(negedge clk);
        up_addr = 16'h2000; up_w_stb = 1'b1; up_r_stb = 1'b1;
        #1;
        chk(dn_w_stb == '0, "R5 no write strobe on miss", dn_w_stb, 0);
        chk(dn_r_stb == '0, "R5 no read strobe on miss", dn_r_stb, 0);
        @(negedge clk);
        up_w_stb = 1'b0;
        #1;
        chk(up_r_data == 8'h00, "R5 read data zero after miss", up_r_data, 0);
    endtask

    task automatic t_writes;
        @(negedge clk);
        up_addr = 16'h0402; up_w_stb = 1'b1; up_r_stb = 1'b0; up_w_data = 8'h3D;
        #1;
        chk(dn_w_stb == 3'b010, "R4 write strobe to window 1", dn_w_stb, 3'b010);
        chk(dn_w_data[8 +: 8] == 8'h3D, "R4 write data to window 1", dn_w_data[8 +: 8], 8'h3D);
        chk(dn_w_data[0 +: 8] == 8'h00 && dn_w_data[16 +: 8] == 8'h00,
            "R4 unselected write data zero", dn_w_data, 24'h003D00);
        chk(dn_addr[0 +: 10] == '0 && dn_addr[20 +: 10] == '0,
            "R4 unselected address zero", dn_addr, 30'h0000_0800);
        chk(dn_r_stb == '0, "R3 no read strobe on write", dn_r_stb, 0);
        @(negedge clk);
        up_addr = 16'h1005; up_w_data = 8'hAA;
        #1;
        chk(dn_w_stb == 3'b100, "R4 write strobe to window 2", dn_w_stb, 3'b100);
        chk(dn_w_data[16 +: 8] == 8'hAA, "R4 write data to window 2", dn_w_data[16 +: 8], 8'hAA);
        @(negedge clk);
        up_w_stb = 1'b0;
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        up_addr = 16'h0001; up_r_stb = 1'b1;
        @(negedge clk);
        up_addr = 16'h1002;
        #1;
        chk(up_r_data == 8'h11, "R6 first read returns window 0", up_r_data, 8'h11);
        @(negedge clk);
        up_addr = 16'h0800; up_r_stb = 1'b0;
        #1;
        chk(up_r_data == 8'h33, "R6 second read returns window 2", up_r_data, 8'h33);
        @(negedge clk);
        up_addr = 16'h0400;
        #1;
        chk(up_r_data == 8'h00, "R5 read data zero after gap", up_r_data, 0);
        @(negedge clk);
        #1;
        chk(up_r_data == 8'h22, "R6 read returns window 1", up_r_data, 8'h22);
        dn_r_data[8 +: 8] = 8'h5A;
        #1;
        chk(up_r_data == 8'h5A, "R6 follows live data of window 1", up_r_data, 8'h5A);
    endtask

    initial begin
        t_reset();
        t_windows();
        t_miss();
        t_writes();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule